// File: doc/BRIEF.md
# Duplicate-Tag Snoop Controller

This controller keeps a cluster of L1 data caches (four by default) coherent with one another. It holds a shadow copy of each cache's line tags and coherence states. When a cache misses, the controller reads all of these shadow copies in one cycle and sends coherence commands only to the caches that really hold the line. Caches that do not hold the line never see any snoop traffic.

When another cache holds the line, it supplies the data directly. This applies to clean copies, which are shared, and to dirty copies, which hand over ownership. Memory is read only when no cache holds the line. A requester also reports its evictions through the same request channel, so the shadow tags always match the caches.

The controller handles one request at a time. Requests that arrive together are served lowest-numbered CPU first. Each request is held until a one-cycle response comes back to its CPU.

Top module: `dtag_snoop_ctrl`

## Requirements
- R1: During reset and after it, no response, snoop or memory request is active until a CPU makes a request.
- R2: Snoops go only to the CPUs whose shadow entry has a matching tag and a state other than Invalid. The requesting CPU is never snooped, even when it holds the line itself. A line at the same set index with a different tag causes no snoop.
- R3: A read (kind 0) that no other CPU holds raises one memory request for the line address. The response then carries the memory data and state Exclusive (code 2).
- R4: A read that only clean holders serve sends share (command 1) to every holder. The data comes from the lowest-numbered holder. The requester gets Shared (code 1), and the holders stay Shared. There is no memory request.
- R5: A read of a line that another CPU holds Modified (code 3) sends migrate (command 2) to that CPU only. The requester gets Modified with that CPU's data, and there is no memory request. The source becomes Invalid, so later requests no longer snoop it.
- R6: A write or ownership miss (kind 1) sends migrate to the lowest-numbered holder and invalidate (command 3) to every other holder. The requester gets Modified (code 3) with the data from that holder. With no holders, the line comes from memory, still in state Modified.
- R7: An eviction notice (kind 2) clears the requester's shadow entry and answers with state Invalid (code 0), with no snoop and no memory request. Later misses to that line do not snoop the evicting CPU.
- R8: Only one transaction is in progress at a time. When several CPUs request in the same cycle, the lowest-numbered one is served first and the others wait.
- R9: Each transaction ends with a response strobe that is one-hot on the requester and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCPU | Per-CPU request, held until its response |
| req_kind | input | 2*NCPU | Per-CPU kind: 0 read, 1 write/ownership, 2 eviction |
| req_addr | input | ADDR_W*NCPU | Per-CPU line address |
| rsp_valid | output | NCPU | One-cycle response strobe per CPU |
| rsp_state | output | 2 | Granted line state: 0 I, 1 S, 2 E, 3 M |
| rsp_data | output | DATA_W | Line data for the responding CPU |
| snp_valid | output | NCPU | Per-CPU snoop command, held until acknowledged |
| snp_cmd | output | 2*NCPU | Per-CPU command: 1 share, 2 migrate, 3 invalidate |
| snp_addr | output | ADDR_W | Line address of the snoops |
| snp_ack | input | NCPU | Per-CPU snoop acknowledge |
| snp_data | input | DATA_W*NCPU | Per-CPU line data, sampled with the acknowledge |
| mem_req_valid | output | 1 | Memory read request, held until answered |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory data valid |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
The bench uses the default parameters: four CPUs, 16-bit line addresses, 16 shadow sets and 32-bit line data. Four CPUs is the smallest cluster in which one miss can see two clean holders and an uninvolved cache at once. It is also the smallest in which a dirty line can pass through several owners in turn. The small set count makes it easy to build addresses that share a set index but differ in tag, which exercises the tag compare against a stale neighbour.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;
  localparam logic [1:0] RQ_EVICT = 2'd2;

  localparam logic [1:0] SN_NONE    = 2'd0;
  localparam logic [1:0] SN_SHARE   = 2'd1;
  localparam logic [1:0] SN_MIGRATE = 2'd2;
  localparam logic [1:0] SN_INVAL   = 2'd3;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_LOOK  = 3'd1,
    FS_SNOOP = 3'd2,
    FS_MEM   = 3'd3,
    FS_RESP  = 3'd4
  } fsm_t;
endpackage

// File: rtl/scu_fixed_arb.sv
module scu_fixed_arb #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req,
  output logic [NCPU-1:0] gnt
);
  always_comb begin
    gnt = req & (~req + 1'b1);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8

  for (genvar g = 1; g < NCPU; g++) begin : g_prio
    AST_GNT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[g] |-> (req[g-1:0] == '0)); // R8
  end
endmodule

// File: rtl/scu_dup_tag_bank.sv
module scu_dup_tag_bank
  import scu_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       lk_state,
  input  logic             wr_en,
  input  logic [1:0]       wr_state
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [1:0]       st_q  [SETS];
  logic [SETS-1:0]  vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < SETS; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
      end
    end else if (wr_en) begin
      vld_q[idx] <= (wr_state != ST_I);
      tag_q[idx] <= tag;
      st_q[idx]  <= wr_state;
    end
  end

  always_comb begin
    if (vld_q[idx] && (tag_q[idx] == tag)) lk_state = st_q[idx];
    else                                    lk_state = ST_I;
  end
endmodule

// File: rtl/scu_snoop_plan.sv
module scu_snoop_plan
  import scu_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [NCPU-1:0]   req_oh,
  input  logic [1:0]        kind,
  input  logic [2*NCPU-1:0] hold_st,
  output logic [NCPU-1:0]   hit,
  output logic [2*NCPU-1:0] cmd,
  output logic [NCPU-1:0]   supplier,
  output logic              need_mem,
  output logic [1:0]        fin_state,
  output logic [NCPU-1:0]   hold_wr,
  output logic [2*NCPU-1:0] hold_new
);
  logic [NCPU-1:0] dirty;
  logic [NCPU-1:0] low_hit;
  logic [NCPU-1:0] low_dirty;

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      hit[i]   = !req_oh[i] && (hold_st[i*2 +: 2] != ST_I);
      dirty[i] = hit[i] && (hold_st[i*2 +: 2] == ST_M);
    end
    low_hit   = hit & (~hit + 1'b1);
    low_dirty = dirty & (~dirty + 1'b1);

    cmd       = '0;
    supplier  = '0;
    need_mem  = 1'b0;
    fin_state = ST_I;
    hold_wr   = '0;
    hold_new  = '0;

    if (kind == RQ_EVICT) begin
      fin_state = ST_I;
    end else if (kind == RQ_WRITE) begin
      fin_state = ST_M;
      if (|hit) begin
        supplier = low_hit;
        hold_wr  = hit;
        for (int i = 0; i < NCPU; i++) begin
          if (low_hit[i])  cmd[i*2 +: 2] = SN_MIGRATE;
          else if (hit[i]) cmd[i*2 +: 2] = SN_INVAL;
          hold_new[i*2 +: 2] = ST_I;
        end
      end else begin
        need_mem = 1'b1;
      end
    end else begin
      if (|dirty) begin
        fin_state = ST_M;
        supplier  = low_dirty;
        hold_wr   = low_dirty;
        for (int i = 0; i < NCPU; i++) begin
          if (low_dirty[i]) cmd[i*2 +: 2] = SN_MIGRATE;
          hold_new[i*2 +: 2] = ST_I;
        end
      end else if (|hit) begin
        fin_state = ST_S;
        supplier  = low_hit;
        hold_wr   = hit;
        for (int i = 0; i < NCPU; i++) begin
          if (hit[i]) cmd[i*2 +: 2] = SN_SHARE;
          hold_new[i*2 +: 2] = ST_S;
        end
      end else begin
        fin_state = ST_E;
        need_mem  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtag_snoop_ctrl.sv
module dtag_snoop_ctrl
  import scu_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCPU-1:0]          req_valid,
  input  logic [2*NCPU-1:0]        req_kind,
  input  logic [ADDR_W*NCPU-1:0]   req_addr,
  output logic [NCPU-1:0]          rsp_valid,
  output logic [1:0]               rsp_state,
  output logic [DATA_W-1:0]        rsp_data,
  output logic [NCPU-1:0]          snp_valid,
  output logic [2*NCPU-1:0]        snp_cmd,
  output logic [ADDR_W-1:0]        snp_addr,
  input  logic [NCPU-1:0]          snp_ack,
  input  logic [DATA_W*NCPU-1:0]   snp_data,
  output logic                     mem_req_valid,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DATA_W-1:0]        mem_rsp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  fsm_t                state_q, state_n;
  logic [NCPU-1:0]     oh_q, oh_n;
  logic [1:0]          kind_q, kind_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [NCPU-1:0]     pend_q, pend_n;
  logic [NCPU-1:0]     sup_q, sup_n;
  logic [NCPU-1:0]     hit_q, hit_n;
  logic [2*NCPU-1:0]   cmd_q, cmd_n;
  logic                mem_q, mem_n;
  logic [1:0]          fin_q, fin_n;
  logic [NCPU-1:0]     hwr_q, hwr_n;
  logic [2*NCPU-1:0]   hnew_q, hnew_n;
  logic [DATA_W-1:0]   data_q, data_n;

  logic [NCPU-1:0]     gnt;
  logic [CPU_W-1:0]    gnt_id;
  logic [2*NCPU-1:0]   hold_st;
  logic [NCPU-1:0]     p_hit, p_sup, p_hwr;
  logic [2*NCPU-1:0]   p_cmd, p_hnew;
  logic                p_mem;
  logic [1:0]          p_fin;
  logic [NCPU-1:0]     bank_we;
  logic [2*NCPU-1:0]   bank_ws;
  logic [IDX_W-1:0]    addr_idx;
  logic [TAG_W-1:0]    addr_tag;

  assign addr_idx = addr_q[IDX_W-1:0];
  assign addr_tag = addr_q[ADDR_W-1:IDX_W];

  scu_fixed_arb #(.NCPU(NCPU)) u_arb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .req   (req_valid),
    .gnt   (gnt)
  );

  always_comb begin
    gnt_id = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (gnt[i]) gnt_id = CPU_W'(i);
    end
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_bank
    assign bank_we[g] = (state_q == FS_RESP) && (oh_q[g] || hwr_q[g]);
    assign bank_ws[g*2 +: 2] = oh_q[g] ? fin_q : hnew_q[g*2 +: 2];

    scu_dup_tag_bank #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .idx      (addr_idx),
      .tag      (addr_tag),
      .lk_state (hold_st[g*2 +: 2]),
      .wr_en    (bank_we[g]),
      .wr_state (bank_ws[g*2 +: 2])
    );
  end

  scu_snoop_plan #(.NCPU(NCPU)) u_plan (
    .req_oh    (oh_q),
    .kind      (kind_q),
    .hold_st   (hold_st),
    .hit       (p_hit),
    .cmd       (p_cmd),
    .supplier  (p_sup),
    .need_mem  (p_mem),
    .fin_state (p_fin),
    .hold_wr   (p_hwr),
    .hold_new  (p_hnew)
  );

  // next-state
  always_comb begin
    state_n = state_q;
    oh_n    = oh_q;
    kind_n  = kind_q;
    addr_n  = addr_q;
    pend_n  = pend_q;
    sup_n   = sup_q;
    hit_n   = hit_q;
    cmd_n   = cmd_q;
    mem_n   = mem_q;
    fin_n   = fin_q;
    hwr_n   = hwr_q;
    hnew_n  = hnew_q;
    data_n  = data_q;
    unique case (state_q)
      FS_IDLE: begin
        if (|gnt) begin
          oh_n    = gnt;
          kind_n  = req_kind[gnt_id*2 +: 2];
          addr_n  = req_addr[gnt_id*ADDR_W +: ADDR_W];
          state_n = FS_LOOK;
        end
      end
      FS_LOOK: begin
        hit_n  = p_hit;
        cmd_n  = p_cmd;
        sup_n  = p_sup;
        mem_n  = p_mem;
        fin_n  = p_fin;
        hwr_n  = p_hwr;
        hnew_n = p_hnew;
        data_n = '0;
        for (int i = 0; i < NCPU; i++) begin
          pend_n[i] = (p_cmd[i*2 +: 2] != SN_NONE);
        end
        if (pend_n != '0) state_n = FS_SNOOP;
        else if (p_mem)   state_n = FS_MEM;
        else              state_n = FS_RESP;
      end
      FS_SNOOP: begin
        pend_n = pend_q & ~snp_ack;
        for (int i = 0; i < NCPU; i++) begin
          if (pend_q[i] && snp_ack[i] && sup_q[i]) data_n = snp_data[i*DATA_W +: DATA_W];
        end
        if (pend_n == '0) state_n = mem_q ? FS_MEM : FS_RESP;
      end
      FS_MEM: begin
        if (mem_rsp_valid) begin
          data_n  = mem_rsp_data;
          state_n = FS_RESP;
        end
      end
      FS_RESP: begin
        state_n = FS_IDLE;
      end
      default: state_n = FS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= FS_IDLE;
      oh_q    <= '0;
      kind_q  <= RQ_READ;
      addr_q  <= '0;
      pend_q  <= '0;
      sup_q   <= '0;
      hit_q   <= '0;
      cmd_q   <= '0;
      mem_q   <= 1'b0;
      fin_q   <= ST_I;
      hwr_q   <= '0;
      hnew_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      oh_q    <= oh_n;
      kind_q  <= kind_n;
      addr_q  <= addr_n;
      pend_q  <= pend_n;
      sup_q   <= sup_n;
      hit_q   <= hit_n;
      cmd_q   <= cmd_n;
      mem_q   <= mem_n;
      fin_q   <= fin_n;
      hwr_q   <= hwr_n;
      hnew_q  <= hnew_n;
      data_q  <= data_n;
    end
  end

  assign snp_valid     = (state_q == FS_SNOOP) ? pend_q : '0;
  assign snp_cmd       = cmd_q;
  assign snp_addr      = addr_q;
  assign mem_req_valid = (state_q == FS_MEM);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state_q == FS_RESP) ? oh_q : '0;
  assign rsp_state     = fin_q;
  assign rsp_data      = data_q;

  AST_SNOOP_FILTERED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snp_valid & ~hit_q) == '0); // R2
  AST_NO_SELF_SNOOP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snp_valid & rsp_valid) == '0 && (snp_valid & oh_q) == '0); // R2
  AST_MEM_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req_valid |-> (hit_q == '0)); // R3
  AST_ONE_SUPPLIER: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(sup_q)); // R4
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(rsp_valid)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|rsp_valid) |=> (rsp_valid == '0)); // R9
  AST_EVICT_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != FS_IDLE && kind_q == RQ_EVICT) |-> (snp_valid == '0 && !mem_req_valid)); // R7
endmodule

// File: tb/dtag_snoop_ctrl_test.sv
`timescale 1ns/1ps
module dtag_snoop_ctrl_test;
  localparam int NCPU   = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETS   = 16;

  logic                   clk;
  logic                   rst_n;
  logic [NCPU-1:0]        req_valid;
  logic [2*NCPU-1:0]      req_kind;
  logic [ADDR_W*NCPU-1:0] req_addr;
  logic [NCPU-1:0]        rsp_valid;
  logic [1:0]             rsp_state;
  logic [DATA_W-1:0]      rsp_data;
  logic [NCPU-1:0]        snp_valid;
  logic [2*NCPU-1:0]      snp_cmd;
  logic [ADDR_W-1:0]      snp_addr;
  logic [NCPU-1:0]        snp_ack;
  logic [DATA_W*NCPU-1:0] snp_data;
  logic                   mem_req_valid;
  logic [ADDR_W-1:0]      mem_req_addr;
  logic                   mem_rsp_valid;
  logic [DATA_W-1:0]      mem_rsp_data;

  int checks = 0;
  int errors = 0;

  dtag_snoop_ctrl #(.NCPU(NCPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) uut (
    .clk, .rst_n, .req_valid, .req_kind, .req_addr, .rsp_valid, .rsp_state, .rsp_data,
    .snp_valid, .snp_cmd, .snp_addr, .snp_ack, .snp_data,
    .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_req(input int cpu, input logic [1:0] kind, input logic [15:0] addr);
    req_valid[cpu]          = 1'b1;
    req_kind[cpu*2 +: 2]    = kind;
    req_addr[cpu*16 +: 16]  = addr;
  endtask

  // services snoops and memory until one response appears
  task automatic service(output int who, output logic [1:0] st, output logic [31:0] dat,
                         output logic [7:0] cmds, output int mems);
    who = -1; st = '0; dat = '0; cmds = '0; mems = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      snp_ack = snp_valid;
      for (int i = 0; i < NCPU; i++) begin
        snp_data[i*32 +: 32] = {8'hCA, 8'(i), snp_addr};
        if (snp_valid[i]) cmds[i*2 +: 2] = snp_cmd[i*2 +: 2];
      end
      mem_rsp_valid = mem_req_valid;
      mem_rsp_data  = {16'hBEEF, mem_req_addr};
      if (mem_req_valid) mems++;
      if (|rsp_valid) begin
        for (int i = 0; i < NCPU; i++) if (rsp_valid[i]) who = i;
        st  = rsp_state;
        dat = rsp_data;
        req_valid[who] = 1'b0;
        break;
      end
    end
  endtask

  task automatic run_txn(input int cpu, input logic [1:0] kind, input logic [15:0] addr,
                         input logic [7:0] exp_cmds, input int exp_mem, input logic [1:0] exp_st,
                         input logic [31:0] exp_dat, input bit chk_dat, input string req);
    int who; logic [1:0] st; logic [31:0] dat; logic [7:0] cmds; int mems;
    drive_req(cpu, kind, addr);
    service(who, st, dat, cmds, mems);
    chk(who == cpu, {req, " responder"}, who, cpu);
    chk(cmds == exp_cmds, {req, " snoop commands"}, {24'h0, cmds}, {24'h0, exp_cmds});
    chk(mems == exp_mem, {req, " memory requests"}, mems, exp_mem);
    chk(st == exp_st, {req, " granted state"}, {30'h0, st}, {30'h0, exp_st});
    if (chk_dat) chk(dat == exp_dat, {req, " data"}, dat, exp_dat);
  endtask

  // R1
  task automatic t_reset;
    chk(rsp_valid == '0 && snp_valid == '0 && !mem_req_valid, "R1 in reset",
        {27'h0, rsp_valid, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rsp_valid == '0 && snp_valid == '0 && !mem_req_valid, "R1 after reset",
        {27'h0, rsp_valid, mem_req_valid}, 32'h0);
  endtask

  // R3, R4, R6, R5: one line passed around the cluster
  task automatic t_line_walk;
    run_txn(0, 2'd0, 16'h0123, 8'h00, 1, 2'd2, 32'hBEEF0123, 1, "R3 read miss no holder");
    run_txn(1, 2'd0, 16'h0123, 8'h01, 0, 2'd1, 32'hCA000123, 1, "R4 clean intervention");
    run_txn(2, 2'd1, 16'h0123, 8'h0E, 0, 2'd3, 32'hCA000123, 1, "R6 write with clean holders");
    run_txn(3, 2'd0, 16'h0123, 8'h20, 0, 2'd3, 32'hCA020123, 1, "R5 dirty migration");
    run_txn(0, 2'd0, 16'h0123, 8'h80, 0, 2'd3, 32'hCA030123, 1, "R5 source invalidated");
  endtask

  // R6, R7
  task automatic t_evict;
    run_txn(1, 2'd1, 16'h0456, 8'h00, 1, 2'd3, 32'hBEEF0456, 1, "R6 write miss no holder");
    run_txn(1, 2'd2, 16'h0456, 8'h00, 0, 2'd0, 32'h0, 0, "R7 eviction notice");
    run_txn(2, 2'd0, 16'h0456, 8'h00, 1, 2'd2, 32'hBEEF0456, 1, "R7 evicted CPU not snooped");
  endtask

  // R2: same set, other tag
  task automatic t_alias;
    run_txn(1, 2'd0, 16'h0F53, 8'h00, 1, 2'd2, 32'hBEEF0F53, 1, "R2 tag mismatch no snoop");
  endtask

  // R8
  task automatic t_arbitrate;
    int who1, who2, m1, m2; logic [1:0] s1, s2; logic [31:0] d1, d2; logic [7:0] c1, c2;
    drive_req(3, 2'd0, 16'h0207);
    drive_req(1, 2'd0, 16'h0308);
    service(who1, s1, d1, c1, m1);
    service(who2, s2, d2, c2, m2);
    chk(who1 == 1, "R8 lower CPU first", who1, 1);
    chk(who2 == 3, "R8 higher CPU second", who2, 3);
    chk(d1 == 32'hBEEF0308 && m1 == 1, "R8 first data", d1, 32'hBEEF0308);
    chk(d2 == 32'hBEEF0207 && m2 == 1, "R8 second data", d2, 32'hBEEF0207);
  endtask

  // R4, R6, R2: exclusive holder downgraded, then upgraded by its owner
  task automatic t_upgrade;
    run_txn(0, 2'd0, 16'h0207, 8'h40, 0, 2'd1, 32'hCA030207, 1, "R4 exclusive holder shares");
    run_txn(3, 2'd1, 16'h0207, 8'h02, 0, 2'd3, 32'hCA000207, 1, "R6 upgrade migrates other copy");
    run_txn(1, 2'd0, 16'h0308, 8'h00, 1, 2'd2, 32'hBEEF0308, 1, "R2 requester own copy excluded");
  endtask

  // R9
  task automatic t_pulse;
    drive_req(2, 2'd0, 16'h0777);
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      mem_rsp_valid = mem_req_valid;
      mem_rsp_data  = {16'hBEEF, mem_req_addr};
      if (|rsp_valid) break;
    end
    chk(rsp_valid == 4'b0100, "R9 one-hot strobe", {28'h0, rsp_valid}, 32'h4);
    @(negedge clk);
    chk(rsp_valid == '0, "R9 single cycle", {28'h0, rsp_valid}, 32'h0);
    req_valid[2] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_kind = '0; req_addr = '0;
    snp_ack = '0; snp_data = '0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_line_walk();
    t_evict();
    t_alias();
    t_arbitrate();
    t_upgrade();
    t_pulse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule